// File: doc/BRIEF.md
# Effective Address Translation Selector

This block sits at the front of a memory management unit. Every accepted access carries an effective address, a fetch/data flag, a write flag, a privilege flag and the two translate-enable bits from the machine state. The block sends each access down exactly one of three paths. If translation is off for that kind of access, it uses real addressing. If translation is on and a block-address entry matches, it uses that block mapping. If no entry matches, it hands the access to the page-translation path.

Two small banks of block-address entries are kept, one for instruction fetches and one for data accesses. A configuration port writes them one entry at a time. Each entry describes a naturally aligned block of 128 KB to 256 MB and its mapping to physical memory. Each entry also has privilege-qualified valid bits and a two-bit protection code. A block hit that breaks protection produces a fault flag for its own side instead of an address.

The result is registered. A ready/valid pair on the request side and on the response side lets a downstream stage stall the block.

Top module: `xlat_sel`

## Requirements
- R1: An accepted fetch (`req_fetch`=1) with `msr_it`=0 yields a response with `rsp_pa_ok`=1 and `rsp_pa` equal to `req_ea`, whatever `msr_dt` and the bank contents are.
- R2: An accepted data access (`req_fetch`=0) with `msr_dt`=0 yields `rsp_pa_ok`=1 and `rsp_pa` equal to `req_ea`, whatever `msr_it` and the bank contents are.
- R3: A translated fetch is matched only against the instruction bank (`cfg_side`=1), and a translated data access only against the data bank (`cfg_side`=0).
- R4: An entry matches only when its valid bit for the current privilege is set (`cfg_sv` when `req_super`=1, `cfg_uv` otherwise) and EA bits [31:17] equal the tag in every bit at or above 17+`cfg_blen`. The block size is 2^(17+`cfg_blen`) bytes, and `cfg_blen` values above 11 act as 11 (256 MB).
- R5: When several entries of the selected bank match, the entry with the lowest index decides the result.
- R6: Protection code 00 allows nothing, 01 and 11 allow reads only, and 10 allows reads and writes. A fetch counts as a read whatever `req_write` says.
- R7: A match that breaks protection sets `rsp_isf` for a fetch or `rsp_dsf` for a data access, never the other one. It also sets `rsp_pa_ok`=0 and `rsp_pa`=0.
- R8: A translated access with no match sets `rsp_walk`=1 and `rsp_pa_ok`=0, and passes the effective address on in `rsp_pa`.
- R9: On a permitted match, `rsp_pa`[16:0] equals EA[16:0]. For each bit 17+i of `rsp_pa`, the value comes from the effective address when i < block length code and from the entry base otherwise.
- R10: The response appears with `rsp_valid` on the clock edge after acceptance. Exactly one of `rsp_pa_ok`, `rsp_walk`, `rsp_isf`, `rsp_dsf` is set. `req_ready` equals `!rsp_valid || rsp_ready`, and a stalled response holds all its fields.
- R11: A configuration write changes the result only for requests accepted on a later edge. A request accepted on the same edge as the write sees the old entry.
- R12: After reset `rsp_valid`=0, `req_ready`=1 and every entry is invalid, so every translated access goes to the page path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this edge |
| req_ea | input | 32 | Effective address |
| req_fetch | input | 1 | 1 = instruction fetch, 0 = data access |
| req_write | input | 1 | 1 = store (data accesses only) |
| req_super | input | 1 | 1 = supervisor privilege |
| msr_it | input | 1 | Instruction translation enable |
| msr_dt | input | 1 | Data translation enable |
| cfg_we | input | 1 | Write one bank entry |
| cfg_side | input | 1 | 1 = instruction bank, 0 = data bank |
| cfg_idx | input | 2 | Entry index |
| cfg_tag | input | 15 | EA bits [31:17] of the block |
| cfg_base | input | 15 | Physical bits [31:17] of the block |
| cfg_blen | input | 4 | Block length code, size 2^(17+code) |
| cfg_sv | input | 1 | Entry valid for supervisor accesses |
| cfg_uv | input | 1 | Entry valid for user accesses |
| cfg_pp | input | 2 | Protection code |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response taken this edge |
| rsp_pa_ok | output | 1 | Physical address issued |
| rsp_walk | output | 1 | Page-path request |
| rsp_isf | output | 1 | Instruction-side protection fault |
| rsp_dsf | output | 1 | Data-side protection fault |
| rsp_pa | output | 32 | Physical address, or EA on a page-path request |

## Verification
Every result is due exactly one edge after the request is accepted. The bench drives requests on the falling edge, lets the rising edge accept them, and reads the response on the following falling edge, where the registered outputs are settled. Configuration writes follow the same rule and count for the next accepted request. For the same-edge case, the expected value is taken from the model before it is updated. While a response is stalled, the bench reads it again on several later falling edges, and it expects the queued request to be accepted only on the edge where `rsp_ready` rises.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
    localparam int ADDR_W = 32;
    localparam int OFS_W  = 17;                 // offset bits of the smallest block
    localparam int SZ_W   = 11;                 // maskable bits above the offset
    localparam int HI_W   = ADDR_W - OFS_W;
    localparam int BL_W   = $clog2(SZ_W + 1);

    typedef enum logic [1:0] {
        PP_NONE = 2'b00,
        PP_RO   = 2'b01,
        PP_RW   = 2'b10,
        PP_RO_B = 2'b11
    } prot_e;

    typedef struct packed {
        logic [HI_W-1:0] tag;
        logic [HI_W-1:0] base;
        logic [BL_W-1:0] blen;
        logic            sv;
        logic            uv;
        prot_e           pp;
    } bat_ent_t;

    typedef struct packed {
        logic              vld;
        logic              pa_ok;
        logic              walk;
        logic              isf;
        logic              dsf;
        logic [ADDR_W-1:0] pa;
    } rsp_t;

    // Bits of the upper address that fall inside the block (taken from EA).
    function automatic logic [HI_W-1:0] blen_mask(input logic [BL_W-1:0] blen);
        logic [HI_W-1:0] m;
        m = '0;
        for (int i = 0; i < SZ_W; i++) begin
            if (i < int'(blen)) m[i] = 1'b1;
        end
        return m;
    endfunction

    function automatic logic prot_ok(input prot_e pp, input logic is_wr);
        logic ok;
        case (pp)
            PP_NONE: ok = 1'b0;
            PP_RW:   ok = 1'b1;
            default: ok = !is_wr;
        endcase
        return ok;
    endfunction
endpackage

// File: rtl/xlat_bat_bank.sv
module xlat_bat_bank
    import xlat_pkg::*;
#(
    parameter  int N_ENT = 4,
    localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   we_i,
    input  logic [IDX_W-1:0]       widx_i,
    input  bat_ent_t               wdata_i,
    output bat_ent_t [N_ENT-1:0]   ents_o
);
    bat_ent_t [N_ENT-1:0] ents_d, ents_q;

    always_comb begin
        ents_d = ents_q;
        for (int i = 0; i < N_ENT; i++) begin
            if (we_i && (int'(widx_i) == i)) ents_d[i] = wdata_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ents_q <= '0;
        else        ents_q <= ents_d;
    end

    assign ents_o = ents_q;
endmodule

// File: rtl/xlat_bat_match.sv
module xlat_bat_match
    import xlat_pkg::*;
#(
    parameter int N_ENT = 4
) (
    input  bat_ent_t [N_ENT-1:0] ents_i,
    input  logic [HI_W-1:0]      ea_hi_i,
    input  logic                 super_i,
    output logic                 hit_o,
    output bat_ent_t             ent_o,
    output logic [HI_W-1:0]      pa_hi_o
);
    logic [N_ENT-1:0] hv;

    for (genvar g = 0; g < N_ENT; g++) begin : g_cmp
        logic [HI_W-1:0] keep;
        logic            priv_ok;
        assign keep    = ~blen_mask(ents_i[g].blen);
        assign priv_ok = super_i ? ents_i[g].sv : ents_i[g].uv;
        assign hv[g]   = priv_ok && (((ea_hi_i ^ ents_i[g].tag) & keep) == '0);
    end

    // Walk from the top down so the lowest matching index is written last.
    always_comb begin
        logic [HI_W-1:0] m;
        hit_o = 1'b0;
        ent_o = '0;
        for (int i = N_ENT - 1; i >= 0; i--) begin
            if (hv[i]) begin
                hit_o = 1'b1;
                ent_o = ents_i[i];
            end
        end
        m       = blen_mask(ent_o.blen);
        pa_hi_o = (ent_o.base & ~m) | (ea_hi_i & m);
    end
endmodule

// File: rtl/xlat_sel.sv
module xlat_sel
    import xlat_pkg::*;
#(
    parameter  int N_ENT = 4,
    localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_ea,
    input  logic              req_fetch,
    input  logic              req_write,
    input  logic              req_super,
    input  logic              msr_it,
    input  logic              msr_dt,
    input  logic              cfg_we,
    input  logic              cfg_side,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [HI_W-1:0]   cfg_tag,
    input  logic [HI_W-1:0]   cfg_base,
    input  logic [BL_W-1:0]   cfg_blen,
    input  logic              cfg_sv,
    input  logic              cfg_uv,
    input  logic [1:0]        cfg_pp,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic              rsp_pa_ok,
    output logic              rsp_walk,
    output logic              rsp_isf,
    output logic              rsp_dsf,
    output logic [ADDR_W-1:0] rsp_pa
);
    localparam int N_SIDE = 2;                  // 0 = data bank, 1 = instruction bank

    bat_ent_t             cfg_ent;
    bat_ent_t [N_ENT-1:0] ents   [N_SIDE];
    logic                 hit    [N_SIDE];
    bat_ent_t             hent   [N_SIDE];
    logic [HI_W-1:0]      pa_hi  [N_SIDE];

    assign cfg_ent = '{tag: cfg_tag, base: cfg_base, blen: cfg_blen,
                       sv: cfg_sv, uv: cfg_uv, pp: prot_e'(cfg_pp)};

    for (genvar s = 0; s < N_SIDE; s++) begin : g_side
        xlat_bat_bank #(.N_ENT(N_ENT)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .we_i    (cfg_we && (cfg_side == s[0])),
            .widx_i  (cfg_idx),
            .wdata_i (cfg_ent),
            .ents_o  (ents[s])
        );
        xlat_bat_match #(.N_ENT(N_ENT)) u_match (
            .ents_i  (ents[s]),
            .ea_hi_i (req_ea[ADDR_W-1:OFS_W]),
            .super_i (req_super),
            .hit_o   (hit[s]),
            .ent_o   (hent[s]),
            .pa_hi_o (pa_hi[s])
        );
    end

    rsp_t rsp_d, rsp_q;
    logic accept;

    assign req_ready = !rsp_q.vld || rsp_ready;
    assign accept    = req_valid && req_ready;

    always_comb begin
        logic            xen;
        logic            sel_hit;
        bat_ent_t        sel_ent;
        logic [HI_W-1:0] sel_hi;
        logic            is_wr;

        xen     = req_fetch ? msr_it : msr_dt;
        sel_hit = req_fetch ? hit[1]   : hit[0];
        sel_ent = req_fetch ? hent[1]  : hent[0];
        sel_hi  = req_fetch ? pa_hi[1] : pa_hi[0];
        is_wr   = !req_fetch && req_write;

        rsp_d = rsp_q;
        if (rsp_q.vld && rsp_ready) rsp_d.vld = 1'b0;

        if (accept) begin
            rsp_d     = '0;
            rsp_d.vld = 1'b1;
            if (!xen) begin
                rsp_d.pa_ok = 1'b1;
                rsp_d.pa    = req_ea;
            end else if (!sel_hit) begin
                rsp_d.walk  = 1'b1;
                rsp_d.pa    = req_ea;
            end else if (!prot_ok(sel_ent.pp, is_wr)) begin
                rsp_d.isf   = req_fetch;
                rsp_d.dsf   = !req_fetch;
            end else begin
                rsp_d.pa_ok = 1'b1;
                rsp_d.pa    = {sel_hi, req_ea[OFS_W-1:0]};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid = rsp_q.vld;
    assign rsp_pa_ok = rsp_q.pa_ok;
    assign rsp_walk  = rsp_q.walk;
    assign rsp_isf   = rsp_q.isf;
    assign rsp_dsf   = rsp_q.dsf;
    assign rsp_pa    = rsp_q.pa;
endmodule

// File: rtl/xlat_sel_chk.sv
module xlat_sel_chk
    import xlat_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ADDR_W-1:0] req_ea,
    input logic              req_fetch,
    input logic              msr_it,
    input logic              msr_dt,
    input logic              rsp_valid,
    input logic              rsp_ready,
    input logic              rsp_pa_ok,
    input logic              rsp_walk,
    input logic              rsp_isf,
    input logic              rsp_dsf,
    input logic [ADDR_W-1:0] rsp_pa
);
    logic acc;
    assign acc = req_valid && req_ready;

    p_real_fetch_r1: assert property (@(posedge clk) disable iff (!rst_n)
        acc && req_fetch && !msr_it |=> rsp_valid && rsp_pa_ok && rsp_pa == $past(req_ea));

    p_real_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
        acc && !req_fetch && !msr_dt |=> rsp_valid && rsp_pa_ok && rsp_pa == $past(req_ea));

    p_no_isf_on_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
        acc && !req_fetch |=> !rsp_isf);

    p_no_dsf_on_fetch_r7: assert property (@(posedge clk) disable iff (!rst_n)
        acc && req_fetch |=> !rsp_dsf);

    p_fault_no_addr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && (rsp_isf || rsp_dsf) |-> !rsp_pa_ok && rsp_pa == '0);

    p_walk_carries_ea_r8: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> !rsp_walk || rsp_pa == $past(req_ea));

    p_offset_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> !rsp_pa_ok || rsp_pa[OFS_W-1:0] == $past(req_ea[OFS_W-1:0]));

    p_due_next_r10: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> rsp_valid);

    p_one_kind_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $countones({rsp_pa_ok, rsp_walk, rsp_isf, rsp_dsf}) == 1);

    p_hold_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_pa)
            && $stable({rsp_pa_ok, rsp_walk, rsp_isf, rsp_dsf}));
endmodule

bind xlat_sel xlat_sel_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_ea    (req_ea),
    .req_fetch (req_fetch),
    .msr_it    (msr_it),
    .msr_dt    (msr_dt),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_pa_ok (rsp_pa_ok),
    .rsp_walk  (rsp_walk),
    .rsp_isf   (rsp_isf),
    .rsp_dsf   (rsp_dsf),
    .rsp_pa    (rsp_pa)
);

// File: tb/xlat_sel_tb_top.sv
`timescale 1ns/1ps
module xlat_sel_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_ea = '0;
    logic        req_fetch = 1'b0, req_write = 1'b0, req_super = 1'b0;
    logic        msr_it = 1'b0, msr_dt = 1'b0;
    logic        cfg_we = 1'b0, cfg_side = 1'b0;
    logic [1:0]  cfg_idx = '0;
    logic [14:0] cfg_tag = '0, cfg_base = '0;
    logic [3:0]  cfg_blen = '0;
    logic        cfg_sv = 1'b0, cfg_uv = 1'b0;
    logic [1:0]  cfg_pp = '0;
    logic        rsp_valid, rsp_ready = 1'b1;
    logic        rsp_pa_ok, rsp_walk, rsp_isf, rsp_dsf;
    logic [31:0] rsp_pa;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;   // 125 MHz

    xlat_sel dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_ea(req_ea),
        .req_fetch(req_fetch), .req_write(req_write), .req_super(req_super),
        .msr_it(msr_it), .msr_dt(msr_dt),
        .cfg_we(cfg_we), .cfg_side(cfg_side), .cfg_idx(cfg_idx),
        .cfg_tag(cfg_tag), .cfg_base(cfg_base), .cfg_blen(cfg_blen),
        .cfg_sv(cfg_sv), .cfg_uv(cfg_uv), .cfg_pp(cfg_pp),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_pa_ok(rsp_pa_ok), .rsp_walk(rsp_walk), .rsp_isf(rsp_isf),
        .rsp_dsf(rsp_dsf), .rsp_pa(rsp_pa)
    );

    // Model of both banks: side 0 = data, side 1 = instruction.
    logic [14:0] m_tag  [2][4];
    logic [14:0] m_base [2][4];
    logic [3:0]  m_blen [2][4];
    logic        m_sv   [2][4];
    logic        m_uv   [2][4];
    logic [1:0]  m_pp   [2][4];

    function automatic logic [14:0] inblk(input logic [3:0] blen);
        logic [14:0] m = '0;
        for (int i = 0; i < 11; i++) if (i < int'(blen)) m[i] = 1'b1;
        return m;
    endfunction

    // Expected {pa_ok, walk, isf, dsf, pa}
    function automatic logic [35:0] predict(input logic [31:0] ea, input logic f,
            input logic wr, input logic sup, input logic it, input logic dt);
        int s = f ? 1 : 0;
        if (!(f ? it : dt)) return {4'b1000, ea};                  // R1, R2
        for (int i = 0; i < 4; i++) begin                          // R5 lowest first
            logic [14:0] m = inblk(m_blen[s][i]);
            if ((sup ? m_sv[s][i] : m_uv[s][i]) &&
                (((ea[31:17] ^ m_tag[s][i]) & ~m) == '0)) begin   // R4
                logic rd_only = f ? 1'b0 : wr;                     // R6
                logic ok = (m_pp[s][i] == 2'b10) ||
                           ((m_pp[s][i] != 2'b00) && !rd_only);
                if (!ok) return {2'b00, f, !f, 32'h0};             // R7
                return {4'b1000, (m_base[s][i] & ~m) | (ea[31:17] & m), ea[16:0]}; // R9
            end
        end
        return {4'b0100, ea};                                      // R8
    endfunction

    task automatic check(input string r, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", r, act, exp);
        end
    endtask

    function automatic logic [35:0] rsp_vec();
        return {rsp_pa_ok, rsp_walk, rsp_isf, rsp_dsf, rsp_pa};
    endfunction

    task automatic drive_cfg(input bit side, input int idx, input logic [14:0] tag,
            input logic [14:0] base, input logic [3:0] blen, input bit sv, input bit uv,
            input logic [1:0] pp);
        cfg_side = side; cfg_idx = idx[1:0]; cfg_tag = tag; cfg_base = base;
        cfg_blen = blen; cfg_sv = sv; cfg_uv = uv; cfg_pp = pp; cfg_we = 1'b1;
    endtask

    task automatic model_cfg();
        int s = cfg_side ? 1 : 0;
        m_tag[s][cfg_idx] = cfg_tag;   m_base[s][cfg_idx] = cfg_base;
        m_blen[s][cfg_idx] = cfg_blen; m_sv[s][cfg_idx] = cfg_sv;
        m_uv[s][cfg_idx] = cfg_uv;     m_pp[s][cfg_idx] = cfg_pp;
    endtask

    task automatic cfg_write(input bit side, input int idx, input logic [14:0] tag,
            input logic [14:0] base, input logic [3:0] blen, input bit sv, input bit uv,
            input logic [1:0] pp);
        @(negedge clk);
        drive_cfg(side, idx, tag, base, blen, sv, uv, pp);
        @(posedge clk); #1;
        cfg_we = 1'b0;
        model_cfg();
    endtask

    task automatic drive_req(input logic [31:0] ea, input bit f, input bit wr,
            input bit sup, input bit it, input bit dt);
        req_ea = ea; req_fetch = f; req_write = wr; req_super = sup;
        msr_it = it; msr_dt = dt; req_valid = 1'b1;
    endtask

    task automatic issue(input string r, input logic [31:0] ea, input bit f,
            input bit wr, input bit sup, input bit it, input bit dt);
        logic [35:0] exp;
        @(negedge clk);
        drive_req(ea, f, wr, sup, it, dt);
        exp = predict(ea, f, wr, sup, it, dt);
        @(posedge clk); #1;
        req_valid = 1'b0;
        @(negedge clk);
        check({r, " valid"}, {63'h0, rsp_valid}, 64'h1);
        check(r, {28'h0, rsp_vec()}, {28'h0, exp});
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        logic [14:0] pool [4];
        logic [35:0] exp;
        logic [35:0] held;
        void'($urandom(32'd4711));
        for (int s = 0; s < 2; s++)
            for (int i = 0; i < 4; i++) begin
                m_tag[s][i] = '0; m_base[s][i] = '0; m_blen[s][i] = '0;
                m_sv[s][i] = 1'b0; m_uv[s][i] = 1'b0; m_pp[s][i] = '0;
            end
        pool[0] = 15'h0000; pool[1] = 15'h1234; pool[2] = 15'h4800; pool[3] = 15'h7FFF;

        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check("R12 rsp_valid after reset", {63'h0, rsp_valid}, 64'h0);
        check("R12 req_ready after reset", {63'h0, req_ready}, 64'h1);
        issue("R12 empty banks walk fetch", 32'h1234_5678, 1, 0, 1, 1, 1);
        issue("R12 empty banks walk data", 32'h0000_0040, 0, 1, 0, 1, 1);

        // Real addressing
        issue("R1 fetch real", 32'hDEAD_BEEF, 1, 1, 0, 0, 1);
        issue("R2 data real", 32'hCAFE_F00D, 0, 1, 1, 1, 0);

        // Instruction bank only: data access to the same address must walk
        cfg_write(1, 0, 15'h0040, 15'h1000, 4'd0, 1, 1, 2'b10);
        issue("R3 fetch hits instr bank", 32'h0080_1234, 1, 0, 0, 1, 1);
        issue("R3 data ignores instr bank", 32'h0080_1234, 0, 0, 0, 1, 1);
        issue("R1 fetch real with entry", 32'h0080_1234, 1, 0, 0, 0, 1);

        // Privilege qualification and block size
        cfg_write(0, 1, 15'h0100, 15'h2200, 4'd2, 1, 0, 2'b10);
        issue("R4 user invalid walks", 32'h0201_0000, 0, 0, 0, 1, 1);
        issue("R4 super hit bit18 differs", 32'h0204_1111, 0, 0, 1, 1, 1);
        issue("R4 bit19 outside block", 32'h0208_0000, 0, 0, 1, 1, 1);
        cfg_write(0, 2, 15'h4000, 15'h0155, 4'd15, 0, 1, 2'b10);
        issue("R4 length code clamps", 32'h8F00_0000, 0, 0, 0, 1, 1);
        issue("R9 merge high bits clamp", 32'h8ABC_DEF0, 0, 1, 0, 1, 1);
        issue("R4 clamp bit28 compared", 32'h9000_0000, 0, 0, 0, 1, 1);

        // Priority: entries 0 and 3 both cover the address
        cfg_write(0, 3, 15'h0300, 15'h7000, 4'd0, 1, 1, 2'b10);
        cfg_write(0, 0, 15'h0300, 15'h5000, 4'd0, 1, 1, 2'b01);
        issue("R5 lowest index wins read", 32'h0600_0004, 0, 0, 0, 1, 1);
        issue("R5 lowest index faults write", 32'h0600_0004, 0, 1, 0, 1, 1);

        // Protection codes
        cfg_write(1, 1, 15'h0050, 15'h0011, 4'd0, 1, 1, 2'b00);
        issue("R7 fetch no access isf", 32'h00A0_0010, 1, 0, 0, 1, 1);
        cfg_write(1, 2, 15'h0051, 15'h0012, 4'd0, 1, 1, 2'b01);
        issue("R6 fetch ignores write flag", 32'h00A2_0020, 1, 1, 0, 1, 1);
        cfg_write(0, 1, 15'h0052, 15'h0013, 4'd1, 1, 1, 2'b11);
        issue("R6 code 11 read ok", 32'h00A5_0030, 0, 0, 0, 1, 1);
        issue("R7 code 11 write dsf", 32'h00A5_0030, 0, 1, 0, 1, 1);
        cfg_write(0, 1, 15'h0052, 15'h0013, 4'd1, 1, 1, 2'b00);
        issue("R7 data no access dsf", 32'h00A4_0030, 0, 0, 0, 1, 1);

        // Same-edge write sees old contents; next request sees new
        @(negedge clk);
        drive_cfg(0, 1, 15'h0052, 15'h0013, 4'd1, 1, 1, 2'b10);
        drive_req(32'h00A4_0040, 0, 1, 0, 1, 1);
        exp = predict(32'h00A4_0040, 0, 1, 0, 1, 1);
        @(posedge clk); #1;
        cfg_we = 1'b0; req_valid = 1'b0;
        model_cfg();
        @(negedge clk);
        check("R11 same edge uses old entry", {28'h0, rsp_vec()}, {28'h0, exp});
        issue("R11 next request uses new entry", 32'h00A4_0040, 0, 1, 0, 1, 1);

        // Stall: response held, second request waits
        @(negedge clk);
        rsp_ready = 1'b0;
        drive_req(32'h0080_0100, 1, 0, 0, 1, 1);
        held = predict(32'h0080_0100, 1, 0, 0, 1, 1);
        @(posedge clk); #1;
        drive_req(32'h1111_2222, 0, 0, 0, 1, 0);
        exp = predict(32'h1111_2222, 0, 0, 0, 1, 0);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check("R10 stalled valid", {63'h0, rsp_valid}, 64'h1);
            check("R10 stalled ready low", {63'h0, req_ready}, 64'h0);
            check("R10 stalled response held", {28'h0, rsp_vec()}, {28'h0, held});
        end
        rsp_ready = 1'b1;
        @(posedge clk); #1;
        req_valid = 1'b0;
        @(negedge clk);
        check("R10 queued request accepted", {63'h0, rsp_valid}, 64'h1);
        check("R10 queued response", {28'h0, rsp_vec()}, {28'h0, exp});
        @(negedge clk);
        check("R10 drained", {63'h0, rsp_valid}, 64'h0);

        // Random mix
        for (int n = 0; n < 600; n++) begin
            logic [14:0] hi;
            logic [31:0] ea;
            if ($urandom_range(0, 7) == 0)
                cfg_write($urandom_range(0, 1), $urandom_range(0, 3),
                          pool[$urandom_range(0, 3)], 15'($urandom),
                          4'($urandom), $urandom_range(0, 1), $urandom_range(0, 1),
                          2'($urandom));
            hi = pool[$urandom_range(0, 3)];
            if ($urandom_range(0, 1) == 1) hi = hi ^ (15'($urandom) & 15'h07FF);
            ea = {hi, 17'($urandom)};
            issue("R4 R6 R9 random", ea, $urandom_range(0, 1), $urandom_range(0, 1),
                  $urandom_range(0, 1), $urandom_range(0, 7) != 0,
                  $urandom_range(0, 7) != 0);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule